// File: doc/BRIEF.md
# Command Slot Status Tracker

This block follows a single command slot of a memory-side accelerator from launch to completion. Software launches a command by writing the low command word with its start bit set; the slot then reports a two-bit status code while an execution engine works on it. The engine signals normal completion, a fault carrying a one-hot cause vector, a hand-off that needs operating-system help, and message-queue results. The block holds the status code, a four-bit substatus, the cause vector, and a flag that says whether the recorded fault is worth retrying. If the command asked for it, the block raises a one-cycle interrupt when the command finishes.

The status code is `0` idle, `1` exception, `2` active and `3` needs-OS. Active and needs-OS together are called busy. Every output is registered, so an input sampled at one rising edge is visible from that edge on.

The command word reaches the block as two plain pins. `cmd_start` is bit 0 of the word. `cmd_notify` is bit 3 of the word, which is the value-4 bit of the mode field held in bits 3:1. The other pins are plain strobes as well. There is no back-pressure: a write is always taken in the cycle it is presented, and a write the slot cannot act on is dropped and recorded in `start_err`.

Top module: `cmd_slot_tracker`

## Requirements
- R1: After reset, `status` is 0 (idle), and `substatus`, `cause`, `retryable`, `irq` and `start_err` are all 0.
- R2: A write with `cmd_start`=1 while the slot is idle or in exception sets `status` to 2 (active) at the next edge. The same write clears `cause`, `substatus` and `retryable`, and latches `cmd_notify` as the interrupt request for this command.
- R3: A write with `cmd_start`=0 changes no output.
- R4: A write with `cmd_start`=1 while busy leaves `status`, `cause`, `substatus` and the latched interrupt request unchanged. It sets `start_err`, which stays 1 until reset.
- R5: `done_stb` while busy moves `status` to 0 and clears `cause` and `retryable`.
- R6: `fault_stb` while busy moves `status` to 1 and captures `fault_cause` into `cause`. A fault wins over a completion in the same cycle. `cause` then holds, ignoring further strobes, until the next accepted start.
- R7: On a fault, `retryable` is 1 exactly when the captured cause is non-zero and every set bit lies in {8, 9, 10, 16}.
- R8: `os_stb` while active, with no fault or completion in that cycle, moves `status` to 3 (needs-OS). From that state a fault or a completion finishes the command as in R5 and R6. `os_stb` in any other state has no effect.
- R9: `mq_stb` while busy loads `substatus[2:0]` with `mq_code` and `substatus[3]` with `mq_abort`. The codes are 0 no error, 1 local buffer overflow, 2 queue limit, 3 page overflow, 4 atomic NACK and 5 put NACK. `mq_stb` while not busy has no effect.
- R10: `irq` is a pulse of exactly one cycle. It is high in the cycle after the edge at which a busy slot moves to idle or exception, and only if the command was started with `cmd_notify`=1. A move to needs-OS raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_start | input | 1 | Start bit (bit 0 of the command word) |
| cmd_notify | input | 1 | Completion-interrupt request (bit 3 of the command word) |
| done_stb | input | 1 | Engine reports normal completion |
| fault_stb | input | 1 | Engine reports a fault |
| fault_cause | input | 18 | One-hot-per-reason cause bits for the fault |
| os_stb | input | 1 | Engine hands the command off to the OS |
| mq_stb | input | 1 | Message-queue result strobe |
| mq_code | input | 3 | Message-queue result code |
| mq_abort | input | 1 | Implicit-abort-active flag |
| status | output | 2 | Slot status code |
| substatus | output | 4 | Abort flag in bit 3, queue result in bits 2:0 |
| cause | output | 18 | Recorded exception cause vector |
| retryable | output | 1 | Recorded fault is retryable |
| irq | output | 1 | Completion interrupt pulse |
| start_err | output | 1 | Sticky flag: a start was written while busy |

## Verification
The bench targets these cases:
- A start written while active or waiting on the OS. A design that accepted it would restart the command and wipe the cause.
- A fault and a completion in the same cycle. The wrong priority would report idle and lose the cause.
- Cause vectors that mix retry bits with a fatal bit, and a zero cause. A loose mask test would mark these retryable.
- Faults, queue results and OS strobes arriving after the command has finished. They must not disturb the held exception record or raise a second interrupt.
- Both interrupt settings and the needs-OS detour. A pulse that stretched, appeared on the hand-off, or appeared without the notify bit would show up at once.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int CAUSE_W = 18;
  localparam int SUB_W   = 4;
  localparam int MQ_W    = SUB_W - 1;
  localparam logic [CAUSE_W-1:0] RETRY_MASK =
    (CAUSE_W'(1) << 8) | (CAUSE_W'(1) << 9) | (CAUSE_W'(1) << 10) | (CAUSE_W'(1) << 16);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXC  = 2'd1,
    ST_ACT  = 2'd2,
    ST_OS   = 2'd3
  } slot_st_e;

  function automatic logic cause_can_retry(input logic [CAUSE_W-1:0] c);
    return (c != '0) && ((c & ~RETRY_MASK) == '0);
  endfunction
endpackage

// File: rtl/slot_fsm.sv
module slot_fsm
  import slot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_wr,
  input  logic     cmd_start,
  input  logic     cmd_notify,
  input  logic     done_stb,
  input  logic     fault_stb,
  input  logic     os_stb,
  output slot_st_e st_q,
  output logic     busy,
  output logic     launch,
  output logic     fault_take,
  output logic     done_take,
  output logic     irq_q,
  output logic     err_q
);
  logic     notify_q;
  slot_st_e st_d;
  logic     finish;

  assign busy       = (st_q == ST_ACT) || (st_q == ST_OS);
  assign launch     = cmd_wr && cmd_start && !busy;
  assign fault_take = busy && fault_stb;
  assign done_take  = busy && done_stb && !fault_stb;
  assign finish     = fault_take || done_take;

  always_comb begin
    st_d = st_q;
    if (launch)                                  st_d = ST_ACT;
    else if (fault_take)                         st_d = ST_EXC;
    else if (done_take)                          st_d = ST_IDLE;
    else if (os_stb && st_q == ST_ACT)           st_d = ST_OS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      notify_q <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= finish && notify_q;
      if (launch) notify_q <= cmd_notify;
      if (cmd_wr && cmd_start && busy) err_q <= 1'b1;
    end
  end

  a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r10_irq_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (st_q == ST_IDLE || st_q == ST_EXC));
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  a_r2_start_goes_active: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_start && !busy) |=> st_q == ST_ACT);
  a_r4_busy_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_start && busy && !fault_stb && !done_stb && !os_stb) |=> $stable(st_q));
endmodule

// File: rtl/slot_cause.sv
module slot_cause
  import slot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               fault_take,
  input  logic               done_take,
  input  logic [CAUSE_W-1:0] fault_cause,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               retry_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      retry_q <= 1'b0;
    end else if (launch || done_take) begin
      cause_q <= '0;
      retry_q <= 1'b0;
    end else if (fault_take) begin
      cause_q <= fault_cause;
      retry_q <= cause_can_retry(fault_cause);
    end
  end

  a_r6_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !fault_take && !done_take) |=> $stable(cause_q) && $stable(retry_q));
  a_r7_retry_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |-> (cause_q != '0) && ((cause_q & ~RETRY_MASK) == '0));
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_take |=> cause_q == '0);
endmodule

// File: rtl/slot_substat.sv
module slot_substat
  import slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             busy,
  input  logic             mq_stb,
  input  logic [MQ_W-1:0]  mq_code,
  input  logic             mq_abort,
  output logic [SUB_W-1:0] sub_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)              sub_q <= '0;
    else if (launch)         sub_q <= '0;
    else if (busy && mq_stb) sub_q <= {mq_abort, mq_code};
  end

  a_r9_idle_mq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> $stable(sub_q));
  a_r9_mq_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mq_stb) |=> sub_q == {$past(mq_abort), $past(mq_code)});
endmodule

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker
  import slot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic               cmd_start,
  input  logic               cmd_notify,
  input  logic               done_stb,
  input  logic               fault_stb,
  input  logic [CAUSE_W-1:0] fault_cause,
  input  logic               os_stb,
  input  logic               mq_stb,
  input  logic [MQ_W-1:0]    mq_code,
  input  logic               mq_abort,
  output logic [1:0]         status,
  output logic [SUB_W-1:0]   substatus,
  output logic [CAUSE_W-1:0] cause,
  output logic               retryable,
  output logic               irq,
  output logic               start_err
);
  slot_st_e st;
  logic     busy, launch, fault_take, done_take;

  slot_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_start(cmd_start),
    .cmd_notify(cmd_notify), .done_stb(done_stb), .fault_stb(fault_stb),
    .os_stb(os_stb), .st_q(st), .busy(busy), .launch(launch),
    .fault_take(fault_take), .done_take(done_take), .irq_q(irq), .err_q(start_err)
  );

  slot_cause u_cause (
    .clk(clk), .rst_n(rst_n), .launch(launch), .fault_take(fault_take),
    .done_take(done_take), .fault_cause(fault_cause), .cause_q(cause), .retry_q(retryable)
  );

  slot_substat u_sub (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .mq_stb(mq_stb),
    .mq_code(mq_code), .mq_abort(mq_abort), .sub_q(substatus)
  );

  assign status = st;

  a_r6_exc_has_cause_path: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && !(cmd_wr && cmd_start)) |=> status == 2'd1);
  a_r1_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0) |-> cause == '0 && !retryable);
endmodule

// File: tb/test_cmd_slot_tracker.sv
module test_cmd_slot_tracker;
  localparam int CW = 18;
  localparam logic [CW-1:0] RMASK = 18'h10700;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, cmd_start = 0, cmd_notify = 0;
  logic done_stb = 0, fault_stb = 0, os_stb = 0, mq_stb = 0, mq_abort = 0;
  logic [CW-1:0] fault_cause = '0;
  logic [2:0] mq_code = '0;
  logic [1:0] status;
  logic [3:0] substatus;
  logic [CW-1:0] cause;
  logic retryable, irq, start_err;

  int checks = 0, errors = 0;
  string phase = "R1";

  logic [1:0] m_st; logic [3:0] m_sub; logic [CW-1:0] m_cause;
  logic m_retry, m_irq, m_err, m_ien;

  always #4 clk = ~clk;

  cmd_slot_tracker i_cmd_slot_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_start(cmd_start),
    .cmd_notify(cmd_notify), .done_stb(done_stb), .fault_stb(fault_stb),
    .fault_cause(fault_cause), .os_stb(os_stb), .mq_stb(mq_stb), .mq_code(mq_code),
    .mq_abort(mq_abort), .status(status), .substatus(substatus), .cause(cause),
    .retryable(retryable), .irq(irq), .start_err(start_err)
  );

  // behavioural reference, updated at each rising edge from the inputs held there
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 2'd0; m_sub = '0; m_cause = '0; m_retry = 0; m_irq = 0; m_err = 0; m_ien = 0;
    end else begin
      m_irq = 0;
      if (m_st == 2'd2 || m_st == 2'd3) begin
        if (mq_stb) m_sub = {mq_abort, mq_code};
        if (cmd_wr && cmd_start) m_err = 1;
        if (fault_stb) begin
          m_st = 2'd1; m_cause = fault_cause;
          m_retry = (fault_cause != 0) && ((fault_cause & ~RMASK) == 0);
          m_irq = m_ien;
        end else if (done_stb) begin
          m_st = 2'd0; m_cause = '0; m_retry = 0; m_irq = m_ien;
        end else if (os_stb && m_st == 2'd2) m_st = 2'd3;
      end else if (cmd_wr && cmd_start) begin
        m_st = 2'd2; m_cause = '0; m_sub = '0; m_retry = 0; m_ien = cmd_notify;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) if (rst_n || phase == "R1") begin
    chk("status", 32'(status), 32'(m_st));
    chk("substatus", 32'(substatus), 32'(m_sub));
    chk("cause", 32'(cause), 32'(m_cause));
    chk("retryable", 32'(retryable), 32'(m_retry));
    chk("irq", 32'(irq), 32'(m_irq));
    chk("start_err", 32'(start_err), 32'(m_err));
  end

  task automatic idle_in();
    cmd_wr = 0; cmd_start = 0; cmd_notify = 0; done_stb = 0; fault_stb = 0;
    os_stb = 0; mq_stb = 0; mq_abort = 0; mq_code = '0; fault_cause = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk); #1; idle_in();
    end
  endtask

  task automatic start(input logic notify);
    cmd_wr = 1; cmd_start = 1; cmd_notify = notify; step(1);
  endtask

  task automatic fault(input logic [CW-1:0] c);
    fault_stb = 1; fault_cause = c; step(1);
  endtask

  task automatic finish_ok();
    done_stb = 1; step(1);
  endtask

  task automatic explicit(input string what, input logic [31:0] act, input logic [31:0] exp);
    chk(what, act, exp);
  endtask

  initial begin
    fork
      begin
        idle_in();
        phase = "R1"; step(3);
        explicit("R1 status after reset", 32'(status), 0);
        rst_n = 1; step(1);

        phase = "R3"; cmd_wr = 1; cmd_start = 0; cmd_notify = 1; step(2);
        explicit("R3 status", 32'(status), 0);

        phase = "R2"; start(0); explicit("R2 active", 32'(status), 2); step(2);
        phase = "R5"; finish_ok(); explicit("R5 idle", 32'(status), 0); step(2);

        phase = "R10"; start(1); step(1); finish_ok(); explicit("R10 irq", 32'(irq), 1);
        step(1); explicit("R10 irq low", 32'(irq), 0);
        start(1); fault(18'h00100); explicit("R10 irq on fault", 32'(irq), 1); step(2);
        start(0); finish_ok(); explicit("R10 no irq", 32'(irq), 0); step(1);

        phase = "R6"; start(1); fault(18'h00022); step(1);
        fault(18'h3FFFF); finish_ok(); mq_stb = 1; mq_code = 3'd4; step(1);
        os_stb = 1; step(2);
        explicit("R6 held cause", 32'(cause), 32'h22);
        start(0); explicit("R2 cause cleared", 32'(cause), 0);
        fault_stb = 1; done_stb = 1; fault_cause = 18'h00400; step(1);
        explicit("R6 fault beats done", 32'(status), 1);

        phase = "R7";
        start(0); fault(18'h10100); explicit("R7 retry", 32'(retryable), 1);
        start(0); fault(18'h00102); explicit("R7 mixed", 32'(retryable), 0);
        start(0); fault(18'h20000); step(1);
        start(0); fault(18'h00000); explicit("R7 zero", 32'(retryable), 0);
        start(0); fault(18'h00200); step(1);

        phase = "R9"; start(0); mq_stb = 1; mq_code = 3'd5; mq_abort = 1; step(1);
        explicit("R9 sub", 32'(substatus), 32'hD);
        mq_stb = 1; mq_code = 3'd2; step(1); finish_ok();
        mq_stb = 1; mq_code = 3'd1; mq_abort = 1; step(2);
        explicit("R9 idle ignore", 32'(substatus), 2);

        phase = "R8"; start(1); os_stb = 1; step(1);
        explicit("R8 needs-os", 32'(status), 3);
        explicit("R10 no irq on handoff", 32'(irq), 0);
        os_stb = 1; mq_stb = 1; mq_code = 3'd3; step(1); finish_ok(); step(1);
        start(0); os_stb = 1; step(1); fault(18'h00001); os_stb = 1; step(2);

        phase = "R4"; start(1); explicit("R4 err clear", 32'(start_err), 0);
        cmd_wr = 1; cmd_start = 1; cmd_notify = 0; step(1);
        explicit("R4 err set", 32'(start_err), 1);
        os_stb = 1; step(1); cmd_wr = 1; cmd_start = 1; step(1);
        finish_ok(); explicit("R4 notify kept", 32'(irq), 1);
        step(3); explicit("R4 sticky", 32'(start_err), 1);
        rst_n = 0; phase = "R1"; step(2); rst_n = 1; step(2);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule